// File: doc/BRIEF.md
# I2C Configuration Save/Restore Controller

This block is an I2C target that owns a bank of byte-wide configuration registers and a non-volatile shadow copy of them. The shadow copy is modelled as an internal register array whose copy operation takes a fixed, parameterized number of cycles. A master reads and writes the live registers with ordinary indexed transfers. Setting one of two command bits in a command register asks the block to copy the live bank into the shadow store, or to reload the live bank from it.

A command is a short write transaction: the target address with the write direction, the command register index, and the command byte. Nothing happens until the master ends the transfer with STOP. The copy then runs. For its whole duration the block leaves its own address unacknowledged, so any master on the bus sees it as busy. Once the copy completes, the command bits clear themselves and the address is acknowledged again. Releasing reset starts an automatic reload of the live bank from the store. The block is ready for traffic once it acknowledges its address.

Both bus lines pass through synchronizers into the system clock. START and STOP are recognised as data-line edges while the clock line is high. The block pulls the data line low through an open-drain style output.

Top module: `cfg_vault`

## Requirements
- R1: When reset is released, `busy` is high and a reload of the live bank from the store runs for CMD_CYCLES cycles. Afterwards every live register equals its stored value, with command bits 3 and 0 of register CMD_REG cleared.
- R2: The block acknowledges the 7-bit address 0x6A (0xD4 as a write byte) while bit 0 of register ADDR_SEL_REG (default 0) is 0, and 0x68 (0xD0) while that bit is 1. Every other address is left unacknowledged.
- R3: A write transfer (address with R/W=0, register index, data bytes) stores each data byte at the index and acknowledges it. The index advances after every byte and wraps from NUM_REGS-1 to 0.
- R4: After the index is written, a repeated START with R/W=1 returns the live register contents from that index. The index advances after each byte while the master acknowledges, and the transfer ends on a master NACK.
- R5: Writing a byte with bit 3 set to register CMD_REG (default 114), followed by STOP, raises `busy` and copies every live register into the store, with the command bits cleared in the stored copy.
- R6: Writing a byte with bit 0 set to register CMD_REG, followed by STOP, raises `busy` and reloads every live register from the store.
- R7: A pending command does not start before STOP. `busy` stays low while the transfer that set the command bit continues.
- R8: While `busy` is high, the block acknowledges no address and never pulls the data line low, so no transfer (and no further command) can reach it. It acknowledges its address again after `busy` falls.
- R9: When a save or a reload completes, bits 3 and 0 of register CMD_REG read back as 0.
- R10: When bits 3 and 0 are both set, only the save is performed, and both bits clear on completion.
- R11: Every `busy` period, whether started by reset or by a command, lasts exactly CMD_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; its release starts the automatic reload |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaDriveLow | output | 1 | 1 pulls the data line low (acknowledge or read data 0) |
| busy | output | 1 | High while a save or reload is running |

## Verification
Register traffic is exercised with a multi-byte write, a read burst that follows a repeated START, and a burst that crosses the top index. Together they separate correct index loading, auto-increment and wrap-around from a pointer that sticks or overflows. The commands are tried separately: save alone, reload alone, and both bits at once. A later reset-triggered reload shows which copy direction really ran. One command transfer is held open without STOP, to show that it does not start early. Address probes sent during a busy period, after it, and after the address-select bit is flipped tell apart the busy refusal, the primary/alternate address choice and a plain address mismatch.

// File: rtl/cfg_vault_pkg.sv
package cfg_vault_pkg;
  localparam int BYTE_W      = 8;
  localparam int SAVE_BIT    = 3;
  localparam int RESTORE_BIT = 0;
  localparam logic [BYTE_W-1:0] CMD_MASK = BYTE_W'((1 << SAVE_BIT) | (1 << RESTORE_BIT));

  typedef struct packed {
    logic              ptrLoad;
    logic              wrEn;
    logic              rdAdv;
    logic              doSave;
    logic              doRestore;
    logic [BYTE_W-1:0] byteVal;
  } vaultStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_REG, ST_REG_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } busState_t;
endpackage

// File: rtl/cfg_vault_sync.sv
module cfg_vault_sync #(
  parameter int                WIDTH     = 2,
  parameter int                STAGES    = 2,
  parameter logic [WIDTH-1:0]  RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RESET_VAL;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/cfg_vault_data.sv
module cfg_vault_data
  import cfg_vault_pkg::*;
#(
  parameter int NUM_REGS     = 128,
  parameter int CMD_REG      = 114,
  parameter int ADDR_SEL_REG = 0,
  parameter int ADDR_SEL_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaultStrobe_t      stb,
  output logic [BYTE_W-1:0] rdData,
  output logic              cmdSave,
  output logic              cmdRestore,
  output logic              addrAlt
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

  logic [BYTE_W-1:0] liveRegs [NUM_REGS];
  logic [BYTE_W-1:0] storeMem [NUM_REGS] = '{default: '0};
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  ptrNext;

  assign ptrNext = (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   ptr <= '0;
    else if (stb.ptrLoad)        ptr <= stb.byteVal[PTR_W-1:0];
    else if (stb.wrEn || stb.rdAdv) ptr <= ptrNext;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] regQ;
    logic              hit;
    assign hit = stb.wrEn && (ptr == PTR_W'(i));
    if (i == CMD_REG) begin : g_cmd
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              regQ <= '0;
        else if (stb.doRestore) regQ <= storeMem[i] & ~CMD_MASK;
        else if (stb.doSave)    regQ <= regQ & ~CMD_MASK;
        else if (hit)           regQ <= stb.byteVal;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              regQ <= '0;
        else if (stb.doRestore) regQ <= storeMem[i];
        else if (hit)           regQ <= stb.byteVal;
      end
    end
    assign liveRegs[i] = regQ;
  end

  always_ff @(posedge clk) begin
    if (stb.doSave) begin
      for (int i = 0; i < NUM_REGS; i++)
        storeMem[i] <= (i == CMD_REG) ? (liveRegs[i] & ~CMD_MASK) : liveRegs[i];
    end
  end

  assign rdData     = liveRegs[ptr];
  assign cmdSave    = liveRegs[CMD_REG][SAVE_BIT];
  assign cmdRestore = liveRegs[CMD_REG][RESTORE_BIT];
  assign addrAlt    = liveRegs[ADDR_SEL_REG][ADDR_SEL_BIT];

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doSave || stb.doRestore) |=> (!cmdSave && !cmdRestore)); // R9
  AST_SAVE_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.doSave |=> storeMem[ADDR_SEL_REG] == $past(liveRegs[ADDR_SEL_REG])); // R5
  AST_RESTORE_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.doRestore |=> liveRegs[ADDR_SEL_REG] == $past(storeMem[ADDR_SEL_REG])); // R6
  AST_NO_WRITE_IN_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doSave || stb.doRestore) |-> !stb.wrEn); // R8
endmodule

// File: rtl/cfg_vault_ctrl.sv
module cfg_vault_ctrl
  import cfg_vault_pkg::*;
#(
  parameter int         CMD_CYCLES  = 400,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] PRI_ADDR    = 7'h6A,
  parameter logic [6:0] ALT_ADDR    = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  input  logic              cmdSave,
  input  logic              cmdRestore,
  input  logic              addrAlt,
  output vaultStrobe_t      stb,
  output logic              sdaDriveLow,
  output logic              busy
);
  localparam int CNT_W = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CMD_CYCLES - 1);
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  logic [1:0] lineSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;

  cfg_vault_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(lineSync)
  );

  assign sclNow = lineSync[1];
  assign sdaNow = lineSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busState_t         state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic              isRead, masterAck, sdaLow;
  logic              byteDone, addrMatch, txLoad;
  logic [CNT_W-1:0]  cnt;
  logic              opSave;

  assign byteDone  = sclFall && (bitCnt == BITS_PER_BYTE);
  assign addrMatch = rxShift[BYTE_W-1:1] == (addrAlt ? ALT_ADDR : PRI_ADDR);
  assign txLoad    = sclFall && (((state == ST_ADDR_ACK) && isRead) ||
                                 ((state == ST_RACK) && masterAck));

  always_comb begin
    stb           = '0;
    stb.byteVal   = rxShift;
    stb.ptrLoad   = !startSeen && !stopSeen && (state == ST_REG) && byteDone;
    stb.wrEn      = !startSeen && !stopSeen && (state == ST_WDATA) && byteDone;
    stb.rdAdv     = !startSeen && !stopSeen && txLoad;
    stb.doSave    = busy && (cnt == '0) && opSave;
    stb.doRestore = busy && (cnt == '0) && !opSave;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sdaLow    <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      sdaLow <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_REG, ST_WDATA: begin
          if (sclRise && (bitCnt < BITS_PER_BYTE)) begin
            rxShift <= {rxShift[BYTE_W-2:0], sdaNow};
            bitCnt  <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrMatch && !busy) begin
                sdaLow <= 1'b1;
                isRead <= rxShift[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sdaLow <= 1'b1;
              state  <= (state == ST_REG) ? ST_REG_ACK : ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              txShift <= rdData;
              sdaLow  <= ~rdData[BYTE_W-1];
              state   <= ST_RDATA;
            end else begin
              sdaLow <= 1'b0;
              state  <= ST_REG;
            end
          end
        end
        ST_REG_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            sdaLow <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == BITS_PER_BYTE - 4'd1) begin
              sdaLow    <= 1'b0;
              bitCnt    <= '0;
              masterAck <= 1'b0;
              state     <= ST_RACK;
            end else begin
              txShift <= {txShift[BYTE_W-2:0], 1'b0};
              sdaLow  <= ~txShift[BYTE_W-2];
              bitCnt  <= bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            masterAck <= ~sdaNow;
          end else if (sclFall) begin
            if (masterAck) begin
              txShift <= rdData;
              sdaLow  <= ~rdData[BYTE_W-1];
              state   <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b1;
      cnt    <= CNT_LOAD;
      opSave <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CNT_W'(1);
    end else if (stopSeen && (cmdSave || cmdRestore)) begin
      busy   <= 1'b1;
      cnt    <= CNT_LOAD;
      opSave <= cmdSave;
    end
  end

  assign sdaDriveLow = sdaLow;

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (state != ST_ADDR_ACK)); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (cnt != '0)) |=> busy); // R11
  AST_START_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen)); // R7
  AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.doSave, stb.doRestore})); // R10
endmodule

// File: rtl/cfg_vault.sv
module cfg_vault
  import cfg_vault_pkg::*;
#(
  parameter int         NUM_REGS     = 128,
  parameter int         CMD_REG      = 114,
  parameter int         ADDR_SEL_REG = 0,
  parameter int         ADDR_SEL_BIT = 0,
  parameter int         CMD_CYCLES   = 400,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [6:0] PRI_ADDR     = 7'h6A,
  parameter logic [6:0] ALT_ADDR     = 7'h68
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow,
  output logic busy
);
  vaultStrobe_t      stb;
  logic [BYTE_W-1:0] rdData;
  logic              cmdSave, cmdRestore, addrAlt;

  cfg_vault_ctrl #(
    .CMD_CYCLES(CMD_CYCLES), .SYNC_STAGES(SYNC_STAGES),
    .PRI_ADDR(PRI_ADDR), .ALT_ADDR(ALT_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .cmdSave(cmdSave), .cmdRestore(cmdRestore), .addrAlt(addrAlt),
    .stb(stb), .sdaDriveLow(sdaDriveLow), .busy(busy)
  );

  cfg_vault_data #(
    .NUM_REGS(NUM_REGS), .CMD_REG(CMD_REG),
    .ADDR_SEL_REG(ADDR_SEL_REG), .ADDR_SEL_BIT(ADDR_SEL_BIT)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdData(rdData), .cmdSave(cmdSave), .cmdRestore(cmdRestore), .addrAlt(addrAlt)
  );
endmodule

// File: tb/cfg_vault_tb.sv
module cfg_vault_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 128;
  localparam int CMD_REG    = 114;
  localparam int CMD_CYCLES = 400;
  localparam int Q          = 5;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaDriveLow, busy;

  assign sdaBus = sdaM & ~sdaDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_vault u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  int busyRun = 0;
  int busyDriveHits = 0;
  bit finished = 1'b0;
  logic [7:0] expLive  [NUM_REGS];
  logic [7:0] expStore [NUM_REGS];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference timing monitor, evaluated every clock
  always @(negedge clk) begin
    if (!rstN) begin
      busyRun = 0;
    end else begin
      if (busy && sdaDriveLow) busyDriveHits++;
      if (busy) busyRun++;
      else if (busyRun != 0) begin
        check(busyRun == CMD_CYCLES, "R11", "busy length", busyRun, CMD_CYCLES);
        busyRun = 0;
      end
    end
  end

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(Q);
      sclM = 1'b1; waitQ(2*Q);
      sclM = 1'b0; waitQ(Q);
    end
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    acked = !sdaBus;
    waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(Q);
      sclM = 1'b1; waitQ(Q);
      b[i] = sdaBus;
      waitQ(Q);
      sclM = 1'b0;
    end
    waitQ(Q);
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(2*Q);
    sclM = 1'b0; waitQ(Q);
    sdaM = 1'b1;
  endtask

  task automatic probe(input logic [6:0] dev, output bit acked);
    busStart();
    sendByte({dev, 1'b0}, acked);
    busStop();
  endtask

  task automatic applyCmdModel();
    if (expLive[CMD_REG][3]) begin
      for (int i = 0; i < NUM_REGS; i++) expStore[i] = expLive[i];
      expStore[CMD_REG][3] = 1'b0; expStore[CMD_REG][0] = 1'b0;
      expLive[CMD_REG][3]  = 1'b0; expLive[CMD_REG][0]  = 1'b0;
    end else if (expLive[CMD_REG][0]) begin
      for (int i = 0; i < NUM_REGS; i++) expLive[i] = expStore[i];
    end
  endtask

  task automatic writeBytes(input logic [6:0] dev, input int idx, input logic [7:0] d [4],
                            input int n, input bit doStop, output bit ok);
    bit a;
    busStart();
    sendByte({dev, 1'b0}, a);
    ok = a;
    if (a) begin
      sendByte(8'(idx), a); ok &= a;
      for (int k = 0; k < n; k++) begin
        sendByte(d[k], a); ok &= a;
      end
    end
    if (ok) for (int k = 0; k < n; k++) expLive[(idx + k) % NUM_REGS] = d[k];
    if (doStop) begin
      busStop();
      applyCmdModel();
    end
  endtask

  task automatic readBytes(input logic [6:0] dev, input int idx, input int n, input string req);
    bit a;
    logic [7:0] got;
    busStart();
    sendByte({dev, 1'b0}, a);
    check(a, req, "address ack before index", a, 1);
    sendByte(8'(idx), a);
    busStart();
    sendByte({dev, 1'b1}, a);
    check(a, req, "address ack for read", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, got);
      check(got == expLive[(idx + k) % NUM_REGS], req, "read data",
            got, expLive[(idx + k) % NUM_REGS]);
    end
    busStop();
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    waitQ(2);
  endtask

  task automatic doReset();
    @(posedge clk); #1 rstN = 1'b0;
    sclM = 1'b1; sdaM = 1'b1;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < NUM_REGS; i++) expLive[i] = expStore[i];
    @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual run still active expected completion");
      finishRun();
    end
  end

  initial begin
    bit ok, a;
    int early;
    for (int i = 0; i < NUM_REGS; i++) begin expStore[i] = '0; expLive[i] = '0; end

    // R1: automatic reload after reset, address refused meanwhile
    doReset();
    check(busy == 1'b1, "R1", "busy right after reset", busy, 1);
    check(sdaDriveLow == 1'b0, "R1", "data line released after reset", sdaDriveLow, 0);
    probe(7'h6A, a);
    check(!a, "R8", "address ack during reset reload", a, 0);
    waitIdle();
    readBytes(7'h6A, 5, 1, "R1");

    // R3/R4: burst write and burst read
    writeBytes(7'h6A, 10, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3, 1'b1, ok);
    check(ok, "R3", "burst write acks", ok, 1);
    readBytes(7'h6A, 10, 3, "R4");

    // R2: foreign address
    probe(7'h2A, a);
    check(!a, "R2", "foreign address ack", a, 0);

    // R3: index wrap
    writeBytes(7'h6A, NUM_REGS - 1, '{8'h77, 8'h02, 8'h00, 8'h00}, 2, 1'b1, ok);
    check(ok, "R3", "wrapping write acks", ok, 1);
    readBytes(7'h6A, NUM_REGS - 1, 2, "R3");

    // R5/R7: save held open until STOP
    writeBytes(7'h6A, CMD_REG, '{8'h08, 8'h00, 8'h00, 8'h00}, 1, 1'b0, ok);
    early = 0;
    repeat (60) begin @(negedge clk); if (busy) early++; end
    check(early == 0, "R7", "busy cycles before STOP", early, 0);
    busStop();
    applyCmdModel();
    check(busy == 1'b1, "R5", "busy after STOP of save", busy, 1);
    probe(7'h6A, a);
    check(!a, "R8", "address ack during save", a, 0);
    waitIdle();
    probe(7'h6A, a);
    check(a, "R8", "address ack after save", a, 1);
    readBytes(7'h6A, CMD_REG, 1, "R9");

    // R6: reload brings back saved values
    writeBytes(7'h6A, 10, '{8'h55, 8'h44, 8'h00, 8'h00}, 2, 1'b1, ok);
    readBytes(7'h6A, 10, 2, "R3");
    writeBytes(7'h6A, CMD_REG, '{8'h01, 8'h00, 8'h00, 8'h00}, 1, 1'b1, ok);
    check(busy == 1'b1, "R6", "busy after STOP of reload", busy, 1);
    waitIdle();
    readBytes(7'h6A, 10, 3, "R6");
    readBytes(7'h6A, 0, 1, "R6");
    readBytes(7'h6A, CMD_REG, 1, "R9");

    // R10: both bits -> save only
    writeBytes(7'h6A, 10, '{8'h66, 8'h00, 8'h00, 8'h00}, 1, 1'b1, ok);
    writeBytes(7'h6A, CMD_REG, '{8'h09, 8'h00, 8'h00, 8'h00}, 1, 1'b1, ok);
    waitIdle();
    readBytes(7'h6A, 10, 1, "R10");
    readBytes(7'h6A, CMD_REG, 1, "R10");
    writeBytes(7'h6A, 10, '{8'h11, 8'h00, 8'h00, 8'h00}, 1, 1'b1, ok);
    doReset();
    check(busy == 1'b1, "R1", "busy after second reset", busy, 1);
    waitIdle();
    readBytes(7'h6A, 10, 3, "R10");

    // R2: alternate address select
    writeBytes(7'h6A, 0, '{8'h03, 8'h00, 8'h00, 8'h00}, 1, 1'b1, ok);
    probe(7'h6A, a);
    check(!a, "R2", "primary address after select", a, 0);
    probe(7'h68, a);
    check(a, "R2", "alternate address after select", a, 1);
    readBytes(7'h68, 0, 1, "R2");

    check(busyDriveHits == 0, "R8", "data line driven while busy", busyDriveHits, 0);
    finishRun();
  end
endmodule